// File: doc/BRIEF.md
# Multi-Format Serial Port Register Front End

This block is the bus-facing register layer of a serial port that can run several framing formats (SPI, I2S and others). A simple 32-bit register bus (select, write flag, address, write data) reaches three control words, an interrupt-control word, a live status word, an interrupt-status window, a data port and two read-only identification words. The serial engines, the interrupt logic and the FIFO storage sit outside; this block exports the control words to them, takes their FIFO fill levels (in bytes) and busy flag back in, and turns bus traffic into one-cycle command strobes for them.

Writing the data port packs the written word into the transmit byte FIFO, low byte first, as many bytes as the current sample width needs and no more than the FIFO has room for. Reading the data port pops the receive side. Control word 2 carries self-clearing command bits (soft reset, transmit flush, receive flush) and, in flash mode, a chip-select index and level that drive one of four chip-select lines. The status word is built each read from live levels, converted from bytes to samples.

A two-state read sequencer governs the read path: state ST_IDLE waits for a request; transition IDLE-to-RDATA on any read request; state ST_RDATA presents the registered read word with the valid flag high; transition RDATA-to-RDATA on a back-to-back read, RDATA-to-IDLE otherwise.

Top module: `ssp_reg_front`

## Requirements
- R1: After reset, control words 0, 1 and 2 read 0, interrupt control reads 0x00002200, all four chip-select lines are high, and the sample width is 8 bits (a data write pushes exactly one byte).
- R2: Control word 0 (offset 0x00), control word 1 (0x04) and interrupt control (0x10) read back what was written; offset 0x60 reads 0x00011901 and 0x64 reads 0x660F0F1F, writes to those two change nothing, and any unmapped offset reads 0.
- R3: Control word 2 (0x08) stores the written value with bits 6, 3 and 2 forced to 0; a write with bit 3 set pulses tx_flush and with bit 2 set pulses rx_flush, each for one cycle after the write.
- R4: A control-word-2 write with bit 6 set pulses soft_reset, tx_flush and rx_flush; if control word 0 bit 11 (flash mode) is set, stored bit 9 becomes 1 and the chip-select line chosen by bits 11:10 goes high.
- R5: In flash mode a control-word-2 write drives the chip-select line indexed by bits 11:10 to the level of bit 9, leaving the others unchanged; outside flash mode the lines do not change.
- R6: The status word (0x0C) holds engine_busy at bit 2, transmit-not-full (tx_level below 64) at bit 1, and at bits 16:12 the low 5 bits of tx_level divided by max(1, width/8), where width is control word 1 bits 21:16 plus 1.
- R7: Status bits 8:4 and 0 depend on control word 0 bits 14:12: value 1 (SPI) gives 16 and 1; value 3 (I2S) gives the receive sample count (same division as R6) and rx_level equal to 64; any other value gives 0.
- R8: A data-port write (0x18) while control word 2 bit 0 (enable) is 0 produces no transmit push.
- R9: An enabled data-port write pulses tx_push one cycle later with tx_push_data equal to the written word and tx_push_cnt equal to the smaller of (1 + [width>8] + [width>16] + [width>24]) and 64 minus tx_level; when that count is 0 no push occurs.
- R10: A data-port read with control word 2 bits 0 and 7 both set raises rx_pop in the request cycle and returns rx_word as sampled then; otherwise rx_pop stays low and the read returns 0.
- R11: A read of offset 0x14 returns irq_status and raises irq_status_rd in the request cycle.
- R12: bus_rvalid is high exactly in the cycle after each read request and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| tx_level | input | LVL_W | Transmit FIFO fill in bytes |
| rx_level | input | LVL_W | Receive FIFO fill in bytes |
| engine_busy | input | 1 | Serial engine busy flag |
| rx_word | input | 32 | Receive FIFO head word |
| irq_status | input | 32 | Interrupt status from interrupt logic |
| ctrl0 | output | 32 | Control word 0 |
| ctrl1 | output | 32 | Control word 1 |
| ctrl2 | output | 32 | Control word 2 |
| irq_ctrl | output | 32 | Interrupt control word |
| cs_lines | output | NUM_CS | Chip-select lines |
| tx_push | output | 1 | Transmit push strobe |
| tx_push_cnt | output | 3 | Bytes to push, low byte first |
| tx_push_data | output | 32 | Word to push |
| tx_flush | output | 1 | Empty transmit FIFO strobe |
| rx_flush | output | 1 | Empty receive FIFO strobe |
| soft_reset | output | 1 | Engine soft reset strobe |
| rx_pop | output | 1 | Receive pop strobe |
| irq_status_rd | output | 1 | Interrupt status read strobe |

## Verification
The assertions watch every cycle for the read-valid timing, the command bits in control word 2 never staying set, transmit pushes only following enabled data writes with a count from 1 to 4, receive pops being followed by valid data, and chip-select lines tracking flash-mode writes. Only the bench scenarios can show the value-level behaviour: the byte-to-sample division in the status word across widths and modes, the push count clipped by free space, the reset values, the identification words and the zero returned by unmapped or disabled reads.

// File: rtl/ssp_regs_pkg.sv
package ssp_regs_pkg;

    localparam int unsigned OFS_CTRL0   = 32'h00;
    localparam int unsigned OFS_CTRL1   = 32'h04;
    localparam int unsigned OFS_CTRL2   = 32'h08;
    localparam int unsigned OFS_STATUS  = 32'h0C;
    localparam int unsigned OFS_IRQCTL  = 32'h10;
    localparam int unsigned OFS_IRQSTAT = 32'h14;
    localparam int unsigned OFS_DATA    = 32'h18;
    localparam int unsigned OFS_VERSION = 32'h60;
    localparam int unsigned OFS_FEATURE = 32'h64;

    localparam logic [31:0] VERSION_WORD = 32'h0001_1901;
    localparam logic [31:0] FEATURE_WORD = 32'h660F_0F1F;
    localparam logic [31:0] IRQCTL_RESET = 32'h0000_2200;

    localparam logic [2:0] FMT_SPI = 3'd1;
    localparam logic [2:0] FMT_I2S = 3'd3;

    // control word 2 bit positions
    localparam int C2_ENABLE  = 0;
    localparam int C2_RXFLUSH = 2;
    localparam int C2_TXFLUSH = 3;
    localparam int C2_SOFTRST = 6;
    localparam int C2_RXEN    = 7;
    localparam int C2_CSLEVEL = 9;
    // control word 0 bit positions
    localparam int C0_FLASH   = 11;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } rd_state_e;

endpackage

// File: rtl/ssp_status_word.sv
module ssp_status_word #(
    parameter int LVL_W      = 7,
    parameter int FIFO_BYTES = 64,
    parameter int FIFO_WORDS = 16
) (
    input  logic [6:0]       width_bits,
    input  logic [2:0]       fmt,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic             busy,
    output logic [31:0]      status
);
    import ssp_regs_pkg::*;

    logic [3:0]       divisor;
    logic [LVL_W-1:0] tx_words;
    logic [LVL_W-1:0] rx_words;

    always_comb begin
        divisor = width_bits[6:3];
        if (divisor == 4'd0) divisor = 4'd1;
        tx_words = tx_lvl / LVL_W'(divisor);
        rx_words = rx_lvl / LVL_W'(divisor);
    end

    always_comb begin
        status        = '0;
        status[2]     = busy;
        status[1]     = (tx_lvl < LVL_W'(FIFO_BYTES));
        status[16:12] = 5'(tx_words);
        unique case (fmt)
            FMT_SPI: begin
                status[0]   = 1'b1;
                status[8:4] = 5'(FIFO_WORDS);
            end
            FMT_I2S: begin
                status[0]   = (rx_lvl == LVL_W'(FIFO_BYTES));
                status[8:4] = 5'(rx_words);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ssp_tx_packer.sv
module ssp_tx_packer #(
    parameter int LVL_W      = 7,
    parameter int FIFO_BYTES = 64
) (
    input  logic [6:0]       width_bits,
    input  logic [LVL_W-1:0] tx_lvl,
    output logic [2:0]       push_cnt
);
    logic [2:0]       need;
    logic [LVL_W-1:0] room;

    always_comb begin
        need = 3'd1;
        if (width_bits > 7'd8)  need = need + 3'd1;
        if (width_bits > 7'd16) need = need + 3'd1;
        if (width_bits > 7'd24) need = need + 3'd1;
        if (tx_lvl >= LVL_W'(FIFO_BYTES)) room = '0;
        else room = LVL_W'(FIFO_BYTES) - tx_lvl;
        if (room < LVL_W'(need)) push_cnt = 3'(room);
        else push_cnt = need;
    end

endmodule

// File: rtl/ssp_cs_drive.sv
module ssp_cs_drive #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [SEL_W-1:0]  sel,
    input  logic              level,
    output logic [NUM_CS-1:0] cs
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cs[i] <= 1'b1;
            else if (upd && sel == SEL_W'(i)) cs[i] <= level;
        end
    end

endmodule

// File: rtl/ssp_reg_front.sv
module ssp_reg_front #(
    parameter int ADDR_W     = 12,
    parameter int FIFO_WORDS = 16,
    parameter int NUM_CS     = 4,
    parameter int FIFO_BYTES = FIFO_WORDS * 4,
    parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              engine_busy,
    input  logic [31:0]       rx_word,
    input  logic [31:0]       irq_status,
    output logic [31:0]       ctrl0,
    output logic [31:0]       ctrl1,
    output logic [31:0]       ctrl2,
    output logic [31:0]       irq_ctrl,
    output logic [NUM_CS-1:0] cs_lines,
    output logic              tx_push,
    output logic [2:0]        tx_push_cnt,
    output logic [31:0]       tx_push_data,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic              soft_reset,
    output logic              rx_pop,
    output logic              irq_status_rd
);
    import ssp_regs_pkg::*;

    localparam int SEL_W = 2;

    rd_state_e   state, state_nx;
    logic        wr_req, rd_req;
    logic        hit_c0, hit_c1, hit_c2, hit_st, hit_ic, hit_is, hit_dt, hit_ver, hit_fea;
    logic [6:0]  width_bits;
    logic [31:0] status_w;
    logic [2:0]  pack_cnt;
    logic [31:0] c2_next;
    logic        cs_upd;
    logic [31:0] rd_mux;

    assign wr_req  = bus_sel &  bus_wr;
    assign rd_req  = bus_sel & ~bus_wr;
    assign hit_c0  = (bus_addr == ADDR_W'(OFS_CTRL0));
    assign hit_c1  = (bus_addr == ADDR_W'(OFS_CTRL1));
    assign hit_c2  = (bus_addr == ADDR_W'(OFS_CTRL2));
    assign hit_st  = (bus_addr == ADDR_W'(OFS_STATUS));
    assign hit_ic  = (bus_addr == ADDR_W'(OFS_IRQCTL));
    assign hit_is  = (bus_addr == ADDR_W'(OFS_IRQSTAT));
    assign hit_dt  = (bus_addr == ADDR_W'(OFS_DATA));
    assign hit_ver = (bus_addr == ADDR_W'(OFS_VERSION));
    assign hit_fea = (bus_addr == ADDR_W'(OFS_FEATURE));

    ssp_status_word #(
        .LVL_W(LVL_W), .FIFO_BYTES(FIFO_BYTES), .FIFO_WORDS(FIFO_WORDS)
    ) u_status (
        .width_bits(width_bits),
        .fmt       (ctrl0[14:12]),
        .tx_lvl    (tx_level),
        .rx_lvl    (rx_level),
        .busy      (engine_busy),
        .status    (status_w)
    );

    ssp_tx_packer #(
        .LVL_W(LVL_W), .FIFO_BYTES(FIFO_BYTES)
    ) u_packer (
        .width_bits(width_bits),
        .tx_lvl    (tx_level),
        .push_cnt  (pack_cnt)
    );

    // command bits never persist; soft reset in flash mode raises the select level
    always_comb begin
        c2_next = bus_wdata;
        c2_next[C2_SOFTRST] = 1'b0;
        c2_next[C2_TXFLUSH] = 1'b0;
        c2_next[C2_RXFLUSH] = 1'b0;
        if (bus_wdata[C2_SOFTRST] && ctrl0[C0_FLASH]) c2_next[C2_CSLEVEL] = 1'b1;
    end

    assign cs_upd = wr_req && hit_c2 && ctrl0[C0_FLASH];

    ssp_cs_drive #(
        .NUM_CS(NUM_CS), .SEL_W(SEL_W)
    ) u_cs (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (cs_upd),
        .sel  (bus_wdata[11:10]),
        .level(c2_next[C2_CSLEVEL]),
        .cs   (cs_lines)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0      <= '0;
            ctrl1      <= '0;
            ctrl2      <= '0;
            irq_ctrl   <= IRQCTL_RESET;
            width_bits <= 7'd8;
        end else if (wr_req) begin
            if (hit_c0) ctrl0 <= bus_wdata;
            if (hit_c1) begin
                ctrl1      <= bus_wdata;
                width_bits <= {1'b0, bus_wdata[21:16]} + 7'd1;
            end
            if (hit_c2) ctrl2 <= c2_next;
            if (hit_ic) irq_ctrl <= bus_wdata;
        end
    end

    // one-cycle command strobes and transmit push
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_flush     <= 1'b0;
            rx_flush     <= 1'b0;
            soft_reset   <= 1'b0;
            tx_push      <= 1'b0;
            tx_push_cnt  <= '0;
            tx_push_data <= '0;
        end else begin
            tx_flush   <= wr_req && hit_c2 && (bus_wdata[C2_SOFTRST] || bus_wdata[C2_TXFLUSH]);
            rx_flush   <= wr_req && hit_c2 && (bus_wdata[C2_SOFTRST] || bus_wdata[C2_RXFLUSH]);
            soft_reset <= wr_req && hit_c2 && bus_wdata[C2_SOFTRST];
            tx_push    <= wr_req && hit_dt && ctrl2[C2_ENABLE] && (pack_cnt != 3'd0);
            if (wr_req && hit_dt) begin
                tx_push_cnt  <= pack_cnt;
                tx_push_data <= bus_wdata;
            end
        end
    end

    assign rx_pop        = rd_req && hit_dt && ctrl2[C2_ENABLE] && ctrl2[C2_RXEN];
    assign irq_status_rd = rd_req && hit_is;

    always_comb begin
        rd_mux = '0;
        if (hit_c0)  rd_mux = ctrl0;
        if (hit_c1)  rd_mux = ctrl1;
        if (hit_c2)  rd_mux = ctrl2;
        if (hit_st)  rd_mux = status_w;
        if (hit_ic)  rd_mux = irq_ctrl;
        if (hit_is)  rd_mux = irq_status;
        if (hit_dt)  rd_mux = rx_pop ? rx_word : 32'd0;
        if (hit_ver) rd_mux = VERSION_WORD;
        if (hit_fea) rd_mux = FEATURE_WORD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
    end

    // read sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else state <= state_nx;
    end

    // read sequencer: transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = rd_req ? ST_RDATA : ST_IDLE;
            ST_RDATA: state_nx = rd_req ? ST_RDATA : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // read sequencer: outputs
    always_comb begin
        bus_rvalid = (state == ST_RDATA);
    end

endmodule

// File: rtl/ssp_reg_front_chk.sv
module ssp_reg_front_chk #(
    parameter int ADDR_W = 12,
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        wr_cs_sel,
    input logic              wr_cs_lvl,
    input logic              wr_soft,
    input logic              flash_on,
    input logic              enable_on,
    input logic [2:0]        cmd_bits,
    input logic              tx_push,
    input logic [2:0]        tx_push_cnt,
    input logic              rx_pop,
    input logic              bus_rvalid,
    input logic [NUM_CS-1:0] cs_lines
);
    logic wr_c2, wr_dt;
    assign wr_c2 = bus_sel && bus_wr && (bus_addr == ADDR_W'(32'h08));
    assign wr_dt = bus_sel && bus_wr && (bus_addr == ADDR_W'(32'h18));

    assert_rvalid_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    assert_no_rvalid_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    assert_cmd_bits_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bits == 3'b000);

    assert_push_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(wr_dt && enable_on));

    assert_push_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (tx_push_cnt >= 3'd1 && tx_push_cnt <= 3'd4));

    assert_pop_then_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> bus_rvalid);

    assert_cs_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c2 && flash_on) |=> (cs_lines[$past(wr_cs_sel)] == $past(wr_cs_lvl || wr_soft)));

    assert_cs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_c2 && flash_on) |=> $stable(cs_lines));

endmodule

bind ssp_reg_front ssp_reg_front_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wr_cs_sel  (bus_wdata[11:10]),
    .wr_cs_lvl  (bus_wdata[9]),
    .wr_soft    (bus_wdata[6]),
    .flash_on   (ctrl0[11]),
    .enable_on  (ctrl2[0]),
    .cmd_bits   ({ctrl2[6], ctrl2[3], ctrl2[2]}),
    .tx_push    (tx_push),
    .tx_push_cnt(tx_push_cnt),
    .rx_pop     (rx_pop),
    .bus_rvalid (bus_rvalid),
    .cs_lines   (cs_lines)
);

// File: tb/tb_ssp_reg_front.sv
`timescale 1ns/1ps
module tb_ssp_reg_front;
    localparam int ADDR_W = 12;
    localparam int LVL_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [LVL_W-1:0]  tx_level = '0, rx_level = '0;
    logic              engine_busy = 1'b0;
    logic [31:0]       rx_word = '0, irq_status = '0;
    logic [31:0]       ctrl0, ctrl1, ctrl2, irq_ctrl;
    logic [3:0]        cs_lines;
    logic              tx_push, tx_flush, rx_flush, soft_reset, rx_pop, irq_status_rd;
    logic [2:0]        tx_push_cnt;
    logic [31:0]       tx_push_data;

    int total = 0, bad = 0;
    bit finished = 0;

    ssp_reg_front dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .tx_level(tx_level), .rx_level(rx_level),
        .engine_busy(engine_busy), .rx_word(rx_word), .irq_status(irq_status),
        .ctrl0(ctrl0), .ctrl1(ctrl1), .ctrl2(ctrl2), .irq_ctrl(irq_ctrl),
        .cs_lines(cs_lines), .tx_push(tx_push), .tx_push_cnt(tx_push_cnt),
        .tx_push_data(tx_push_data), .tx_flush(tx_flush), .rx_flush(rx_flush),
        .soft_reset(soft_reset), .rx_pop(rx_pop), .irq_status_rd(irq_status_rd)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // pulses captured one cycle after the write edge
    logic p_push, p_txf, p_rxf, p_soft;
    logic [2:0] p_cnt;
    logic [31:0] p_data;

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        p_push = tx_push; p_cnt = tx_push_cnt; p_data = tx_push_data;
        p_txf = tx_flush; p_rxf = rx_flush; p_soft = soft_reset;
        check("R12 no valid after write", {31'd0, bus_rvalid}, 32'd0);
    endtask

    logic r_pop, r_isr;
    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        r_pop = rx_pop; r_isr = irq_status_rd;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        check("R12 valid after read", {31'd0, bus_rvalid}, 32'd1);
    endtask

    function automatic logic [31:0] exp_status(int w, int fmt, int txl, int rxl, bit busy);
        logic [31:0] s = '0;
        int dv = w / 8;
        if (dv == 0) dv = 1;
        s[2] = busy;
        s[1] = (txl < 64);
        s[16:12] = 5'((txl / dv) % 32);
        if (fmt == 1) begin s[0] = 1'b1; s[8:4] = 5'd16; end
        else if (fmt == 3) begin s[0] = (rxl == 64); s[8:4] = 5'((rxl / dv) % 32); end
        return s;
    endfunction

    function automatic int exp_cnt(int w, int txl);
        int n = 1 + (w > 8) + (w > 16) + (w > 24);
        int room = 64 - txl;
        return (room < n) ? room : n;
    endfunction

    initial begin
        logic [31:0] rd;
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        do_read(12'h000, rd); check("R1 ctrl0 reset", rd, 32'h0);
        do_read(12'h004, rd); check("R1 ctrl1 reset", rd, 32'h0);
        do_read(12'h008, rd); check("R1 ctrl2 reset", rd, 32'h0);
        do_read(12'h010, rd); check("R1 irq ctrl reset", rd, 32'h0000_2200);
        check("R1 cs reset", {28'd0, cs_lines}, 32'hF);

        // R8 disabled data write
        do_write(12'h018, 32'hDEAD_BEEF);
        check("R8 no push when disabled", {31'd0, p_push}, 32'd0);

        // R1/R9 default width pushes one byte
        do_write(12'h008, 32'h1);
        do_write(12'h018, 32'hAABB_CCDD);
        check("R1 push at reset width", {31'd0, p_push}, 32'd1);
        check("R1 one byte", {29'd0, p_cnt}, 32'd1);
        check("R9 push data", p_data, 32'hAABB_CCDD);

        // R2 identification and readback
        do_read(12'h060, rd); check("R2 version", rd, 32'h0001_1901);
        do_write(12'h060, 32'h0);
        do_read(12'h060, rd); check("R2 version write ignored", rd, 32'h0001_1901);
        do_write(12'h064, 32'h0);
        do_read(12'h064, rd); check("R2 feature", rd, 32'h660F_0F1F);
        do_read(12'h040, rd); check("R2 unmapped", rd, 32'h0);
        do_write(12'h010, 32'h0000_5A3C);
        do_read(12'h010, rd); check("R2 irq ctrl readback", rd, 32'h0000_5A3C);
        do_write(12'h000, 32'h0000_0234);
        do_read(12'h000, rd); check("R2 ctrl0 readback", rd, 32'h0000_0234);

        // R3 flush bits
        do_write(12'h008, 32'h0000_000D);
        check("R3 tx flush", {31'd0, p_txf}, 32'd1);
        check("R3 rx flush", {31'd0, p_rxf}, 32'd1);
        check("R3 no soft reset", {31'd0, p_soft}, 32'd0);
        do_read(12'h008, rd); check("R3 ctrl2 cleared bits", rd, 32'h1);
        do_write(12'h008, 32'h0000_0009);
        check("R3 tx flush only", {30'd0, p_txf, p_rxf}, 32'd2);

        // R5 flash mode select
        do_write(12'h000, 32'h0000_0800);
        do_write(12'h008, (32'd2 << 10) | 32'h1);
        check("R5 cs line 2 low", {28'd0, cs_lines}, 32'hB);
        // R4 soft reset in flash mode
        do_write(12'h008, (32'd2 << 10) | 32'h41);
        check("R4 soft reset pulse", {29'd0, p_soft, p_txf, p_rxf}, 32'd7);
        check("R4 cs line raised", {28'd0, cs_lines}, 32'hF);
        do_read(12'h008, rd); check("R4 ctrl2 level bit", rd, 32'h0000_0A01);
        // R5 non-flash mode leaves lines
        do_write(12'h000, 32'h0);
        do_write(12'h008, (32'd1 << 10) | 32'h1);
        check("R5 no change outside flash", {28'd0, cs_lines}, 32'hF);

        // R10 data reads
        rx_word = 32'h1234_5678;
        do_read(12'h018, rd);
        check("R10 no pop rx disabled", {31'd0, r_pop}, 32'd0);
        check("R10 zero data rx disabled", rd, 32'h0);
        do_write(12'h008, 32'h81);
        do_read(12'h018, rd);
        check("R10 pop", {31'd0, r_pop}, 32'd1);
        check("R10 data", rd, 32'h1234_5678);

        // R11 interrupt status read
        irq_status = 32'h9;
        do_read(12'h014, rd);
        check("R11 strobe", {31'd0, r_isr}, 32'd1);
        check("R11 value", rd, 32'h9);

        // R9 full FIFO and partial room
        do_write(12'h004, 32'd31 << 16);
        tx_level = 7'd64;
        do_write(12'h018, 32'h1111_2222);
        check("R9 no push when full", {31'd0, p_push}, 32'd0);
        tx_level = 7'd62;
        do_write(12'h018, 32'h3333_4444);
        check("R9 clipped count", {29'd0, p_cnt}, 32'd2);

        // R6/R7/R9 random mix
        for (int i = 0; i < 40; i++) begin
            int w, fm, txl, rxl;
            bit bz;
            logic [31:0] wd;
            w   = $urandom_range(1, 64);
            fm  = $urandom_range(0, 4);
            txl = ($urandom_range(0, 3) == 0) ? 64 : $urandom_range(0, 64);
            rxl = ($urandom_range(0, 3) == 0) ? 64 : $urandom_range(0, 64);
            bz  = 1'($urandom_range(0, 1));
            wd  = $urandom;
            do_write(12'h004, 32'(w - 1) << 16);
            do_write(12'h000, 32'(fm) << 12);
            tx_level = 7'(txl); rx_level = 7'(rxl); engine_busy = bz;
            do_read(12'h00C, rd);
            check("R6 R7 status word", rd, exp_status(w, fm, txl, rxl, bz));
            do_write(12'h018, wd);
            check("R9 push flag", {31'd0, p_push}, {31'd0, exp_cnt(w, txl) != 0});
            if (exp_cnt(w, txl) != 0) begin
                check("R9 push count", {29'd0, p_cnt}, 32'(exp_cnt(w, txl)));
                check("R9 push word", p_data, wd);
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule